// File: doc/BRIEF.md
# Byte-Addressed Multi-Cycle Processor

This block is a small multi-cycle processor. Its instructions are 16 bits wide, but its memory holds 8-bit cells, so every instruction is read as two bytes at consecutive addresses. The machine keeps a program counter, an instruction register and a bank of sixteen 8-bit general-purpose registers. Each instruction passes through fetch, decode and execute, and the control sequence then starts over. Four operations are recognised: load a register from memory, store a register to memory, add two registers and write the sum to a third, and halt.

After reset the machine sits in the halted state. A pulse on the start input copies the start address into the program counter and begins fetching. The memory port is a synchronous single-port bus: read data arrives one clock after the address. Once a halt instruction executes, the machine stops issuing writes and raises its halted output. It stays halted until start is pulsed again. Register contents survive a halt and restart.

Top module: `byte_fetch_cpu`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, halted is 1, mem_we is 0 and mem_addr is 0x00. All sixteen registers are cleared to zero.
- R2: While halted is 1, a start pulse loads start_addr into the program counter. In the next cycle halted is 0 and mem_addr equals start_addr.
- R3: A fetch reads address PC and then PC+1 in consecutive cycles, modulo 256. The byte at PC is the high byte of the instruction, holding the opcode in bits 15:12 and the first operand in bits 11:8. The byte at PC+1 is the low byte. The program counter advances by 2, modulo 256, before the instruction executes.
- R4: Opcode 0x1, encoded as 1RXY, loads register R with the memory byte at address XY.
- R5: Opcode 0x3, encoded as 3RXY, writes register R to memory address XY in a single cycle with mem_we high.
- R6: Opcode 0x5, encoded as 5RST, writes (reg S + reg T) mod 256 into register R. No carry is kept and no flag is set. R may equal S or T, and S may equal T.
- R7: Opcode 0xC halts the machine whatever its low 12 bits are. While halted, mem_addr shows the program counter, which is the halt instruction's address plus 2.
- R8: Every opcode other than 0x1, 0x3, 0x5 and 0xC does nothing. It writes no memory and changes no register.
- R9: Load takes 6 cycles. Store, add, halt and no-operation each take 5 cycles: fetch-high, fetch-low, latch, decode and execute.
- R10: While halted and start is low, mem_we stays 0, mem_addr holds steady and halted stays 1.
- R11: The sixteen registers are selected by 4-bit fields and are independent of one another. Their values are kept across a halt and a later start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, sampled while halted |
| start_addr | input | 8 | Address loaded into the program counter on start |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after its address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | High while the machine is stopped |

## Verification
The adder is swept over all 256 combinations of source and destination register numbers. Each combination uses its own operand pair, so a wrong field position or a swap of S, T and R changes the stored sum. The cases where both sources are the same register show that the second load overwrote the first. Every undefined opcode is tried with operand bits that would alter a register or memory cell if it were misdecoded as a load, store or add. Programs that start at 0xFE and 0xFF separate correct modulo-256 fetch from fetch that runs off the end of memory. Loading and then storing all sixteen registers catches aliasing between register select lines.

// File: rtl/cpu_pkg.sv
// cpu_pkg: shared widths, opcode values, sequencer states and the decoded
// instruction record for the byte-addressed processor.
// Assumes a 16-bit instruction made of two DATA_W-bit bytes, and an address
// field exactly two register selectors wide.
package cpu_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int SEL_W   = 4;
    localparam int OP_W    = 4;
    localparam int INSTR_W = OP_W + SEL_W + ADDR_W;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OP_W-1:0] OPC_STORE = 4'h3;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'hC;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_LATCH,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD_WB
    } cpu_state_e;

    typedef enum logic [2:0] {
        K_NOP,
        K_LOAD,
        K_STORE,
        K_ADD,
        K_HALT
    } cpu_kind_e;

    typedef struct packed {
        cpu_kind_e          kind;
        logic [SEL_W-1:0]   rd;
        logic [SEL_W-1:0]   rs;
        logic [SEL_W-1:0]   rt;
        logic [ADDR_W-1:0]  addr;
    } cpu_dec_t;

endpackage

// File: rtl/cpu_decode.sv
// cpu_decode: purely combinational split of an instruction word into its
// operation kind and operand fields.
// Assumes the opcode sits in the top OP_W bits, the first operand right
// below it, and the address field overlapping the two source selectors.
module cpu_decode
    import cpu_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int SW = SEL_W,
    parameter int AW = ADDR_W,
    parameter int OW = OP_W
) (
    input  logic [IW-1:0] instr_i,
    output cpu_dec_t      dec_o
);

    logic [OW-1:0] opcode;

    assign opcode = instr_i[IW-1 -: OW];

    // Map the opcode to an operation kind; anything unknown becomes a no-op.
    always_comb begin
        dec_o.rd   = instr_i[AW +: SW];
        dec_o.rs   = instr_i[SW +: SW];
        dec_o.rt   = instr_i[0 +: SW];
        dec_o.addr = instr_i[0 +: AW];
        case (opcode)
            OPC_LOAD:  dec_o.kind = K_LOAD;
            OPC_STORE: dec_o.kind = K_STORE;
            OPC_ADD:   dec_o.kind = K_ADD;
            OPC_HALT:  dec_o.kind = K_HALT;
            default:   dec_o.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/cpu_regfile.sv
// cpu_regfile: bank of 2**SW registers of DW bits, one write port and three
// combinational read ports.
// Assumes at most one write per cycle; reads return the pre-write value.
module cpu_regfile #(
    parameter int DW = 8,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [SW-1:0] wsel_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [SW-1:0] rsel_a_i,
    input  logic [SW-1:0] rsel_b_i,
    input  logic [SW-1:0] rsel_c_i,
    output logic [DW-1:0] rdata_a_o,
    output logic [DW-1:0] rdata_b_o,
    output logic [DW-1:0] rdata_c_o
);

    localparam int NREGS = 1 << SW;

    logic [NREGS-1:0][DW-1:0] bank;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic [DW-1:0] q;

        // Hold one register; clear on reset, load when selected for write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we_i && (wsel_i == SW'(i))) begin
                q <= wdata_i;
            end
        end

        assign bank[i] = q;
    end

    assign rdata_a_o = bank[rsel_a_i];
    assign rdata_b_o = bank[rsel_b_i];
    assign rdata_c_o = bank[rsel_c_i];

endmodule

// File: rtl/cpu_sequencer.sv
// cpu_sequencer: control state machine, program counter and instruction
// register. It drives the memory address and write strobe and the
// register-file write controls.
// Assumes the memory returns read data one clock after the address is
// presented, and that the instruction is exactly two bytes wide.
module cpu_sequencer
    import cpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [DW-1:0] mem_rdata_i,
    input  cpu_dec_t      dec_i,
    output logic [IW-1:0] instr_o,
    output cpu_dec_t      dec_q_o,
    output cpu_state_e    state_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_we_o,
    output logic          rf_we_o,
    output logic          rf_from_mem_o,
    output logic          halted_o
);

    localparam logic [AW-1:0] STEP_ONE = AW'(1);
    localparam logic [AW-1:0] STEP_TWO = AW'(2);

    cpu_state_e    state_q;
    logic [AW-1:0] pc_q;
    logic [IW-1:0] ir_q;
    cpu_dec_t      dec_q;

    // Advance the fetch/decode/execute sequence and its PC, IR and decode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            pc_q    <= '0;
            ir_q    <= '0;
            dec_q   <= '0;
        end else begin
            case (state_q)
                ST_HALT: begin
                    if (start_i) begin
                        pc_q    <= start_addr_i;
                        state_q <= ST_FETCH_HI;
                    end
                end
                ST_FETCH_HI: begin
                    state_q <= ST_FETCH_LO;
                end
                ST_FETCH_LO: begin
                    ir_q[IW-1 -: DW] <= mem_rdata_i;
                    state_q          <= ST_LATCH;
                end
                ST_LATCH: begin
                    ir_q[DW-1:0] <= mem_rdata_i;
                    pc_q         <= pc_q + STEP_TWO;
                    state_q      <= ST_DECODE;
                end
                ST_DECODE: begin
                    dec_q   <= dec_i;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    case (dec_q.kind)
                        K_LOAD:  state_q <= ST_LOAD_WB;
                        K_HALT:  state_q <= ST_HALT;
                        default: state_q <= ST_FETCH_HI;
                    endcase
                end
                ST_LOAD_WB: begin
                    state_q <= ST_FETCH_HI;
                end
                default: begin
                    state_q <= ST_HALT;
                end
            endcase
        end
    end

    // Choose the memory address: next instruction byte, operand address or PC.
    always_comb begin
        mem_addr_o = pc_q;
        if (state_q == ST_FETCH_LO) begin
            mem_addr_o = pc_q + STEP_ONE;
        end else if (state_q == ST_EXEC &&
                     (dec_q.kind == K_LOAD || dec_q.kind == K_STORE)) begin
            mem_addr_o = dec_q.addr;
        end
    end

    // Derive write strobes for memory and register file from the current step.
    always_comb begin
        mem_we_o      = (state_q == ST_EXEC) && (dec_q.kind == K_STORE);
        rf_from_mem_o = (state_q == ST_LOAD_WB);
        rf_we_o       = rf_from_mem_o ||
                        ((state_q == ST_EXEC) && (dec_q.kind == K_ADD));
    end

    assign halted_o = (state_q == ST_HALT);
    assign state_o  = state_q;
    assign instr_o  = ir_q;
    assign dec_q_o  = dec_q;

endmodule

// File: rtl/byte_fetch_cpu.sv
// byte_fetch_cpu: top of the byte-addressed multi-cycle processor. It wires
// the sequencer, decoder, register bank and the two's complement adder.
// Assumes a synchronous single-port byte memory with one cycle of read
// latency, and start pulses applied only while halted.
module byte_fetch_cpu
    import cpu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic          halted
);

    localparam int IW = 2 * DW;

    cpu_state_e    state;
    cpu_dec_t      dec_now;
    cpu_dec_t      dec_q;
    logic [IW-1:0] instr;
    logic          rf_we;
    logic          rf_from_mem;
    logic [DW-1:0] src_s;
    logic [DW-1:0] src_t;
    logic [DW-1:0] src_r;
    logic [DW-1:0] add_sum;
    logic [DW-1:0] rf_wdata;

    cpu_sequencer #(
        .DW (DW),
        .AW (AW),
        .IW (IW)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .start_addr_i  (start_addr),
        .mem_rdata_i   (mem_rdata),
        .dec_i         (dec_now),
        .instr_o       (instr),
        .dec_q_o       (dec_q),
        .state_o       (state),
        .mem_addr_o    (mem_addr),
        .mem_we_o      (mem_we),
        .rf_we_o       (rf_we),
        .rf_from_mem_o (rf_from_mem),
        .halted_o      (halted)
    );

    cpu_decode #(
        .IW (IW),
        .SW (SW),
        .AW (AW),
        .OW (OP_W)
    ) u_dec (
        .instr_i (instr),
        .dec_o   (dec_now)
    );

    cpu_regfile #(
        .DW (DW),
        .SW (SW)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .wsel_i    (dec_q.rd),
        .wdata_i   (rf_wdata),
        .rsel_a_i  (dec_q.rs),
        .rsel_b_i  (dec_q.rt),
        .rsel_c_i  (dec_q.rd),
        .rdata_a_o (src_s),
        .rdata_b_o (src_t),
        .rdata_c_o (src_r)
    );

    // Two's complement sum; the carry out is dropped by the width.
    assign add_sum   = src_s + src_t;
    assign rf_wdata  = rf_from_mem ? mem_rdata : add_sum;
    assign mem_wdata = src_r;

endmodule

// File: rtl/byte_fetch_cpu_checker.sv
// byte_fetch_cpu_checker: temporal properties of the processor, attached to
// every instance of the top module by the bind below.
// Assumes it sees the top's ports and its sequencer state.
module byte_fetch_cpu_checker
    import cpu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] start_addr,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          halted,
    input cpu_state_e    state
);

    // R10: a halted machine never writes memory.
    p_no_write_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R10: without start, halted stays high and the address holds.
    p_hold_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(mem_addr)));

    // R2: start leaves halt and presents the start address.
    p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start) |=> (!halted && mem_addr == $past(start_addr)));

    // R3: the second fetch byte comes from the next address.
    p_fetch_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_HI) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R5: a write happens only in execute, right after decode.
    p_write_in_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_EXEC && $past(state) == ST_DECODE));

    // R9: the load write-back step only follows execute.
    p_load_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_WB) |-> ($past(state) == ST_EXEC));

endmodule

bind byte_fetch_cpu byte_fetch_cpu_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .halted     (halted),
    .state      (state)
);

// File: tb/byte_fetch_cpu_test.sv
module byte_fetch_cpu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_addr = 8'h00;
    logic [7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       mem_we;
    logic       halted;

    logic [7:0] mem [256];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int         cyc;
    logic [7:0] first_addr;
    logic [7:0] second_addr;
    logic [7:0] halt_addr;
    bit         left_halt;

    always #5 clk = ~clk;

    byte_fetch_cpu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_we     (mem_we),
        .halted     (halted)
    );

    // Synchronous byte memory with one cycle of read latency.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [3:0] r,
                                       input logic [7:0] xy);
        return {op, r, xy};
    endfunction

    task automatic put16(input logic [7:0] a, input logic [15:0] w);
        mem[a]         = w[15:8];
        mem[8'(a + 1)] = w[7:0];
    endtask

    task automatic run(input logic [7:0] sa);
        @(negedge clk);
        start_addr = sa;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        first_addr = mem_addr;
        left_halt = !halted;
        second_addr = 8'h00;
        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            if (cyc == 1) second_addr = mem_addr;
        end
        halt_addr = mem_addr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(halted == 1'b1, "R1 halted in reset", int'(halted), 1);
        check(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(halted == 1'b1, "R1 halted after reset", int'(halted), 1);
        check(mem_addr == 8'h00, "R1 reset address", int'(mem_addr), 0);
        check(mem_we == 1'b0, "R1 reset write", int'(mem_we), 0);

        // R1/R11: a register never written reads as zero after reset.
        mem[8'h80] = 8'hEE;
        put16(8'h10, mk(4'h3, 4'h9, 8'h80));
        put16(8'h12, 16'hC000);
        run(8'h10);
        check(left_halt, "R2 leaves halt", int'(left_halt), 1);
        check(first_addr == 8'h10, "R2 start address", int'(first_addr), 'h10);
        check(second_addr == 8'h11, "R3 second fetch byte", int'(second_addr), 'h11);
        check(mem[8'h80] == 8'h00, "R1 cleared register", int'(mem[8'h80]), 0);
        check(cyc == 10, "R9 store+halt cycles", cyc, 10);
        check(halt_addr == 8'h14, "R7 pc after halt", int'(halt_addr), 'h14);

        // R4 R5 R6 R9: adder sweep over all register field combinations.
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [3:0] rs, rt, rd;
                logic [7:0] va, vb, expv;
                rs = 4'(a);
                rt = 4'(b);
                rd = 4'(a + b);
                va = 8'((a * 37 + 11) & 255);
                vb = 8'((b * 53 + 200) & 255);
                expv = (rs == rt) ? 8'(vb + vb) : 8'(va + vb);
                mem[8'h80] = va;
                mem[8'h81] = vb;
                mem[8'h82] = 8'h5A;
                put16(8'h20, mk(4'h1, rs, 8'h80));
                put16(8'h22, mk(4'h1, rt, 8'h81));
                put16(8'h24, {4'h5, rd, rs, rt});
                put16(8'h26, mk(4'h3, rd, 8'h82));
                put16(8'h28, 16'hC000);
                run(8'h20);
                check(mem[8'h82] == expv, "R6 add sum via R4 load R5 store",
                      int'(mem[8'h82]), int'(expv));
                check(cyc == 27, "R9 load/load/add/store/halt cycles", cyc, 27);
                check(halt_addr == 8'h2A, "R7 halt address", int'(halt_addr), 'h2A);
            end
        end

        // R8: every undefined opcode is a no-operation.
        for (int op = 0; op < 16; op++) begin
            if (op != 1 && op != 3 && op != 5 && op != 12) begin
                mem[8'h90] = 8'hA5;
                mem[8'h91] = 8'h3C;
                mem[8'h92] = 8'h00;
                put16(8'h40, mk(4'h1, 4'h2, 8'h90));
                put16(8'h42, mk(4'(op), 4'h2, 8'h91));
                put16(8'h44, mk(4'h3, 4'h2, 8'h92));
                put16(8'h46, 16'hC000);
                run(8'h40);
                check(mem[8'h92] == 8'hA5, "R8 register untouched by no-op",
                      int'(mem[8'h92]), 'hA5);
                check(mem[8'h91] == 8'h3C, "R8 memory untouched by no-op",
                      int'(mem[8'h91]), 'h3C);
                check(cyc == 21, "R8 R9 no-op cycles", cyc, 21);
            end
        end

        // R7 R3: halt at the top of memory wraps the program counter.
        put16(8'hFE, 16'hC000);
        run(8'hFE);
        check(cyc == 5, "R7 halt cycles", cyc, 5);
        check(halt_addr == 8'h00, "R3 pc wraps past FF", int'(halt_addr), 0);

        // R7: opcode C halts whatever its operand bits hold.
        put16(8'h50, 16'hC123);
        mem[8'h23] = 8'h77;
        run(8'h50);
        check(halt_addr == 8'h52, "R7 halt with operands", int'(halt_addr), 'h52);
        check(mem[8'h23] == 8'h77, "R7 halt writes nothing", int'(mem[8'h23]), 'h77);

        // R11 R3: register kept across halt; instruction split across FF/00.
        mem[8'hB0] = 8'h6D;
        mem[8'hA0] = 8'h00;
        put16(8'h60, mk(4'h1, 4'h7, 8'hB0));
        put16(8'h62, 16'hC000);
        run(8'h60);
        put16(8'hFF, mk(4'h3, 4'h7, 8'hA0));
        put16(8'h01, 16'hC000);
        run(8'hFF);
        check(first_addr == 8'hFF, "R3 fetch high at FF", int'(first_addr), 'hFF);
        check(second_addr == 8'h00, "R3 fetch low wraps to 00", int'(second_addr), 0);
        check(mem[8'hA0] == 8'h6D, "R11 register kept across halt", int'(mem[8'hA0]), 'h6D);
        check(halt_addr == 8'h03, "R7 halt address after wrap", int'(halt_addr), 3);

        // R10: quiet while halted with start low.
        begin
            logic [7:0] hold;
            bit         quiet;
            hold = mem_addr;
            quiet = 1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mem_we || !halted || mem_addr != hold) quiet = 0;
            end
            check(quiet, "R10 halted stays quiet", int'(quiet), 1);
        end

        // R11: sixteen independent registers.
        for (int i = 0; i < 16; i++) begin
            mem[8'hC0 + i] = 8'((i * 29 + 3) & 255);
            mem[8'hD0 + i] = 8'hFF;
            put16(8'(2 * i), mk(4'h1, 4'(i), 8'(8'hC0 + i)));
            put16(8'(32 + 2 * i), mk(4'h3, 4'(i), 8'(8'hD0 + i)));
        end
        put16(8'h40, 16'hC000);
        run(8'h00);
        for (int i = 0; i < 16; i++) begin
            check(mem[8'hD0 + i] == 8'((i * 29 + 3) & 255), "R11 register bank",
                  int'(mem[8'hD0 + i]), (i * 29 + 3) & 255);
        end
        check(cyc == 181, "R9 bank program cycles", cyc, 181);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule